// File: doc/BRIEF.md
# H-Bridge Chopper Control

This block is the digital control core of a full-bridge motor winding driver. It runs on the oscillator clock and turns a direction bit, an enable bit, a decay-mode bit, a current-trip comparator input and two supply-fault flags into four registered gate enables: high-side and low-side for each of the two bridge legs.

While enabled, the block drives one diagonal pair of switches. The direction bit selects which pair. Two kinds of chopping stop conduction:

- **External chopping.** The enable input is pulsed low.
- **Internal regulation.** The trip comparator clears a source-enable latch. The latch stays clear for a fixed number of oscillator cycles and is then set again.

In both cases the recirculation path follows the decay-mode bit:

- **Fast decay** turns on the opposite diagonal.
- **Slow decay** turns on both low sides.

The supply-fault flags mask the outputs. A direction change inserts one cycle with every switch off.

Top module: `hbridge_chopper`

## Requirements
- R1: With enable high and the latch set, direction 0 gives low-side A and high-side B on (`{a_hi,a_lo,b_hi,b_lo}` = 0110), and direction 1 gives high-side A and low-side B on (1001).
- R2: With enable low and decay bit 0, the opposite diagonal conducts: 1001 for direction 0 and 0110 for direction 1.
- R3: With enable low and decay bit 1, both low sides are on and both high sides are off (0101), for either direction.
- R4: A trip sampled while the latch is set turns conduction off. The outputs show the recirculation pattern chosen by the decay bit (as in R2/R3) starting one cycle after the trip edge.
- R5: The recirculation after a trip lasts exactly OFF_CYCLES (default 96) clock cycles. Conduction then resumes without any further stimulus.
- R6: Trip assertions during an active off-time are ignored, and the off-time is not restarted or extended.
- R7: A regulator fault sampled at an edge forces all four outputs off after that edge.
- R8: A charge-pump fault sampled at an edge forces both high-side outputs off after that edge and leaves the low sides as they would otherwise be.
- R9: The high and low outputs of one leg are never on together. A direction change yields exactly one cycle of all outputs off before the new pattern appears.
- R10: A synchronous reset forces all outputs off, clears the off-time and sets the latch. After release, conduction starts on the next edge.
- R11: While enable is high and the latch is set, the decay bit has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| dir | input | 1 | Direction select |
| en | input | 1 | Bridge enable (external chopping when low) |
| decay_slow | input | 1 | Recirculation mode: 0 fast, 1 slow |
| trip | input | 1 | Current-trip comparator output |
| reg_fault | input | 1 | Regulator supply fault |
| cp_fault | input | 1 | Charge-pump supply fault |
| a_hi | output | 1 | Leg A high-side gate enable |
| a_lo | output | 1 | Leg A low-side gate enable |
| b_hi | output | 1 | Leg B high-side gate enable |
| b_lo | output | 1 | Leg B low-side gate enable |

## Verification
A latch that stays clear, or an off-time counter that is loaded wrongly, shows up at the ports as a recirculation window of the wrong length. This error becomes visible on the 96th or 97th cycle after the trip. A stale direction register shows as a missing or extra all-off cycle directly after a direction change. Because the outputs are registered, every other decode error appears on the first edge after the stimulus.

// File: rtl/hbridge_chopper.sv
module hbridge_chopper #(
  parameter int OFF_CYCLES = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic dir,
  input  logic en,
  input  logic decay_slow,
  input  logic trip,
  input  logic reg_fault,
  input  logic cp_fault,
  output logic a_hi,
  output logic a_lo,
  output logic b_hi,
  output logic b_lo
);
  localparam int CW = (OFF_CYCLES > 1) ? $clog2(OFF_CYCLES) : 1;

  logic          src_en;
  logic [CW-1:0] off_cnt;
  logic          dir_q;
  logic [3:0]    gates, pat, nxt;

  wire conduct = en && src_en;

  always_comb begin
    if (conduct)         pat = dir ? 4'b1001 : 4'b0110;
    else if (decay_slow) pat = 4'b0101;
    else                 pat = dir ? 4'b0110 : 4'b1001;
    nxt = pat;
    if (cp_fault) begin
      nxt[3] = 1'b0;
      nxt[1] = 1'b0;
    end
    if (reg_fault || (dir != dir_q)) nxt = 4'b0000;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_en  <= 1'b1;
      off_cnt <= '0;
      dir_q   <= 1'b0;
      gates   <= 4'b0000;
    end else begin
      dir_q <= dir;
      gates <= nxt;
      if (src_en) begin
        if (trip) begin
          src_en  <= 1'b0;
          off_cnt <= CW'(OFF_CYCLES - 1);
        end
      end else if (off_cnt == '0) begin
        src_en <= 1'b1;
      end else begin
        off_cnt <= off_cnt - CW'(1);
      end
    end
  end

  assign {a_hi, a_lo, b_hi, b_lo} = gates;
endmodule

// File: rtl/hbridge_chopper_chk.sv
module hbridge_chopper_chk #(
  parameter int OFF_CYCLES = 96,
  localparam int CW = (OFF_CYCLES > 1) ? $clog2(OFF_CYCLES) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          dir,
  input logic          trip,
  input logic          reg_fault,
  input logic          cp_fault,
  input logic          a_hi,
  input logic          a_lo,
  input logic          b_hi,
  input logic          b_lo,
  input logic          src_en,
  input logic [CW-1:0] off_cnt
);
  p_leg_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(a_hi && a_lo) && !(b_hi && b_lo));

  p_dir_blank_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && ($past(dir) != $past(dir, 2)))
      |-> !(a_hi || a_lo || b_hi || b_lo));

  p_reg_fault_r7: assert property (@(posedge clk) disable iff (rst)
    $past(reg_fault) |-> !(a_hi || a_lo || b_hi || b_lo));

  p_cp_fault_r8: assert property (@(posedge clk) disable iff (rst)
    $past(cp_fault) |-> !(a_hi || b_hi));

  p_trip_start_r4: assert property (@(posedge clk) disable iff (rst)
    (src_en && trip) |=> (!src_en && off_cnt == CW'(OFF_CYCLES - 1)));

  p_off_count_r6: assert property (@(posedge clk) disable iff (rst)
    (!src_en && off_cnt != '0) |=> (!src_en && off_cnt == $past(off_cnt) - CW'(1)));

  p_resume_r5: assert property (@(posedge clk) disable iff (rst)
    (!src_en && off_cnt == '0) |=> src_en);
endmodule

bind hbridge_chopper hbridge_chopper_chk #(.OFF_CYCLES(OFF_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .dir(dir), .trip(trip),
  .reg_fault(reg_fault), .cp_fault(cp_fault),
  .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
  .src_en(src_en), .off_cnt(off_cnt)
);

// File: tb/tb_hbridge_chopper.sv
module tb_hbridge_chopper;
  localparam int OFF = 96;
  logic clk = 1'b0;
  logic rst, dir, en, decay_slow, trip, reg_fault, cp_fault;
  logic a_hi, a_lo, b_hi, b_lo;
  int applied = 0, miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hbridge_chopper #(.OFF_CYCLES(OFF)) dut (
    .clk(clk), .rst(rst), .dir(dir), .en(en), .decay_slow(decay_slow),
    .trip(trip), .reg_fault(reg_fault), .cp_fault(cp_fault),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo));

  // {req[3:0], dir, en, slow, reg_fault, cp_fault, expected {a_hi,a_lo,b_hi,b_lo}}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {4'd1,  5'b01000, 4'b0110},  // R1
    {4'd1,  5'b11000, 4'b1001},  // R1
    {4'd2,  5'b00000, 4'b1001},  // R2
    {4'd2,  5'b10000, 4'b0110},  // R2
    {4'd3,  5'b00100, 4'b0101},  // R3
    {4'd3,  5'b10100, 4'b0101},  // R3
    {4'd7,  5'b01010, 4'b0000},  // R7
    {4'd7,  5'b10010, 4'b0000},  // R7
    {4'd8,  5'b01001, 4'b0100},  // R8
    {4'd8,  5'b00001, 4'b0001},  // R8
    {4'd8,  5'b10101, 4'b0101},  // R8
    {4'd11, 5'b11100, 4'b1001}   // R11
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] exp, input int req);
    logic [3:0] got;
    got = {a_hi, a_lo, b_hi, b_lo};
    applied++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL R%0d: outputs %b expected %b", req, got, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; dir = 1'b0; en = 1'b1; decay_slow = 1'b0; trip = 1'b0;
    reg_fault = 1'b0; cp_fault = 1'b0;
    @(negedge clk);
    tick();
    chk(4'b0000, 10);                   // R10 outputs off in reset
    rst = 1'b0;
    tick();
    chk(4'b0110, 10);                   // R10 conduction right after release

    for (int i = 0; i < NV; i++) begin
      {dir, en, decay_slow, reg_fault, cp_fault} = VEC[i][8:4];
      tick();
      tick();
      chk(VEC[i][3:0], int'(VEC[i][12:9]));
    end

    // R4/R5: fast-decay internal off-time
    dir = 1'b0; en = 1'b1; decay_slow = 1'b0; reg_fault = 1'b0; cp_fault = 1'b0;
    tick(); tick();
    chk(4'b0110, 1);
    trip = 1'b1;
    tick();
    trip = 1'b0;
    chk(4'b0110, 4);
    tick();
    chk(4'b1001, 4);                    // R4 fast recirculation
    repeat (OFF - 1) tick();
    chk(4'b1001, 5);                    // R5 still off at cycle 96
    tick();
    chk(4'b0110, 5);                    // R5 resumes

    // R4/R6: slow-decay off-time, trips during it ignored
    decay_slow = 1'b1;
    tick();
    trip = 1'b1;
    tick();
    trip = 1'b0;
    tick();
    chk(4'b0101, 4);                    // R4 slow recirculation
    repeat (40) tick();
    trip = 1'b1;
    repeat (10) tick();
    trip = 1'b0;
    chk(4'b0101, 6);
    repeat (OFF - 1 - 50) tick();
    chk(4'b0101, 6);                    // R6 not extended
    tick();
    chk(4'b0110, 6);                    // R6 resumes on schedule

    // R9: direction change dead cycle
    decay_slow = 1'b0;
    tick();
    dir = 1'b1;
    tick();
    chk(4'b0000, 9);
    tick();
    chk(4'b1001, 9);
    dir = 1'b0;
    tick();
    chk(4'b0000, 9);

    // R10: reset in mid off-time
    tick();
    trip = 1'b1;
    tick();
    trip = 1'b0;
    repeat (5) tick();
    rst = 1'b1;
    tick();
    chk(4'b0000, 10);
    rst = 1'b0;
    tick();
    chk(4'b0110, 10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule